// File: doc/BRIEF.md
# Two-Road Crossing Light Sequencer

This block drives the signal heads at a junction of two roads, called road A and road B. Each road has one vehicle-presence input. The input is high for as long as cars wait on or approach that road. The block holds one of four states in a 2-bit register. The two light codes are decoded from that state alone, so a change on a presence input is seen at the lights only after the next rising clock edge.

Road A gets green after reset. A road keeps its green while its own presence input is high. When that input drops, the road moves to yellow for exactly one cycle, and then the other road gets green. At most one road shows anything other than red at any time. The state codes and the light codes are fixed. Parameters choose how the next-state logic and the output decode are built: as reduced sum-of-products equations or as case tables. Both choices give identical behaviour.

Top module: `crossing_light_ctrl`

## Requirements
- R1: Reset is synchronous and active high. At the first rising edge with `rst` high, the lights become A green and B red, whatever the presence inputs are.
- R2: Each light code is 2'b00 for green, 2'b01 for yellow or 2'b10 for red. The code 2'b11 never appears on either light output.
- R3: While A is green and `sense_a` is high at a rising edge, A stays green and B stays red after that edge. `sense_b` has no effect.
- R4: While A is green and `sense_a` is low at a rising edge, the next cycle shows A yellow and B red.
- R5: A yellow lasts one cycle. After it, B is green and A is red, whatever the presence inputs are.
- R6: While B is green and `sense_b` is high at a rising edge, B stays green and A stays red after that edge. `sense_a` has no effect.
- R7: While B is green and `sense_b` is low at a rising edge, the next cycle shows B yellow and A red.
- R8: B yellow lasts one cycle. After it, A is green and B is red, whatever the presence inputs are.
- R9: In no cycle are both `light_a` and `light_b` different from red (2'b10).
- R10: The light outputs depend only on the stored state. Changing the presence inputs between clock edges leaves both light outputs unchanged until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| sense_a | input | 1 | High while traffic is present on road A |
| sense_b | input | 1 | High while traffic is present on road B |
| light_a | output | 2 | Light code for road A (00 green, 01 yellow, 10 red) |
| light_b | output | 2 | Light code for road B (00 green, 01 yellow, 10 red) |

## Verification
The outputs are decoded straight from the state register, so the light pair reveals the stored state in every cycle. Any wrong state or wrong transition shows up on `light_a` or `light_b` in the cycle right after the faulty clock edge. A missing advance out of yellow is a special case: it shows as a yellow that lasts a second cycle. A swapped hold condition shows as a green that ends even though its presence input was high, or that continues after the input went low. Comparing both outputs with a reference model in every cycle therefore catches any error within one clock.

// File: rtl/crossing_light_pkg.sv
package crossing_light_pkg;

   localparam int STATE_W = 2;
   localparam int LIGHT_W = 2;

   typedef logic [STATE_W-1:0] state_t;
   typedef logic [LIGHT_W-1:0] light_t;

   // state codes: bit 1 selects the road holding right of way (0 = A, 1 = B),
   // bit 0 marks the yellow phase of that road
   localparam state_t ST_A_GO   = 2'b00;
   localparam state_t ST_A_WARN = 2'b01;
   localparam state_t ST_B_GO   = 2'b10;
   localparam state_t ST_B_WARN = 2'b11;

   localparam light_t LT_GREEN  = 2'b00;
   localparam light_t LT_YELLOW = 2'b01;
   localparam light_t LT_RED    = 2'b10;

endpackage

// File: rtl/crossing_light_next.sv
module crossing_light_next
   import crossing_light_pkg::*;
#(
   parameter bit USE_SOP = 1'b1
) (
   input  state_t cur,
   input  logic   sense_a,
   input  logic   sense_b,
   output state_t nxt
);

   generate
      if (USE_SOP) begin : g_sop
         // reduced equations for the fixed state code
         always_comb begin
            nxt[1] = cur[1] ^ cur[0];
            nxt[0] = (~cur[1] & ~cur[0] & ~sense_a) |
                     ( cur[1] & ~cur[0] & ~sense_b);
         end
      end else begin : g_table
         always_comb begin
            unique case (cur)
               ST_A_GO:   nxt = sense_a ? ST_A_GO : ST_A_WARN;
               ST_A_WARN: nxt = ST_B_GO;
               ST_B_GO:   nxt = sense_b ? ST_B_GO : ST_B_WARN;
               ST_B_WARN: nxt = ST_A_GO;
               default:   nxt = ST_A_GO;
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/crossing_light_dec.sv
module crossing_light_dec
   import crossing_light_pkg::*;
#(
   parameter bit USE_SOP = 1'b1
) (
   input  state_t cur,
   output light_t lamp_a,
   output light_t lamp_b
);

   generate
      if (USE_SOP) begin : g_sop
         always_comb begin
            lamp_a[1] =  cur[1];
            lamp_a[0] = ~cur[1] &  cur[0];
            lamp_b[1] = ~cur[1];
            lamp_b[0] =  cur[1] &  cur[0];
         end
      end else begin : g_table
         always_comb begin
            unique case (cur)
               ST_A_GO:   begin lamp_a = LT_GREEN;  lamp_b = LT_RED;    end
               ST_A_WARN: begin lamp_a = LT_YELLOW; lamp_b = LT_RED;    end
               ST_B_GO:   begin lamp_a = LT_RED;    lamp_b = LT_GREEN;  end
               ST_B_WARN: begin lamp_a = LT_RED;    lamp_b = LT_YELLOW; end
               default:   begin lamp_a = LT_RED;    lamp_b = LT_RED;    end
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/crossing_light_sreg.sv
module crossing_light_sreg #(
   parameter int            WIDTH     = 2,
   parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("crossing_light_sreg: WIDTH must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) q <= RESET_VAL;
      else     q <= d;
   end

endmodule

// File: rtl/crossing_light_ctrl.sv
module crossing_light_ctrl
   import crossing_light_pkg::*;
#(
   parameter bit SOP_NEXT = 1'b1,
   parameter bit SOP_DEC  = 1'b1
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       sense_a,
   input  logic       sense_b,
   output logic [1:0] light_a,
   output logic [1:0] light_b
);

   localparam int NUM_STATES = 1 << STATE_W;

   generate
      if (STATE_W != 2 || NUM_STATES != 4) begin : g_bad_state
         $error("crossing_light_ctrl: the fixed state code needs exactly 2 bits");
      end
      if (LIGHT_W != 2) begin : g_bad_light
         $error("crossing_light_ctrl: light codes must be 2 bits wide");
      end
   endgenerate

   state_t cur_st;
   state_t nxt_st;
   light_t lamp_a;
   light_t lamp_b;

   crossing_light_next #(.USE_SOP(SOP_NEXT)) u_next (
      .cur     (cur_st),
      .sense_a (sense_a),
      .sense_b (sense_b),
      .nxt     (nxt_st)
   );

   crossing_light_sreg #(.WIDTH(STATE_W), .RESET_VAL(ST_A_GO)) u_sreg (
      .clk (clk),
      .rst (rst),
      .d   (nxt_st),
      .q   (cur_st)
   );

   crossing_light_dec #(.USE_SOP(SOP_DEC)) u_dec (
      .cur    (cur_st),
      .lamp_a (lamp_a),
      .lamp_b (lamp_b)
   );

   assign light_a = lamp_a;
   assign light_b = lamp_b;

endmodule

// File: rtl/crossing_light_chk.sv
module crossing_light_chk
   import crossing_light_pkg::*;
(
   input logic       clk,
   input logic       rst,
   input logic       sense_a,
   input logic       sense_b,
   input logic [1:0] light_a,
   input logic [1:0] light_b
);

   AST_RESET_STATE: assert property (@(posedge clk)
      rst |=> (light_a == LT_GREEN && light_b == LT_RED)); // R1

   AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (rst)
      (light_a != 2'b11 && light_b != 2'b11)); // R2

   AST_A_HOLD: assert property (@(posedge clk) disable iff (rst)
      (light_a == LT_GREEN && sense_a) |=> (light_a == LT_GREEN && light_b == LT_RED)); // R3

   AST_A_WARN: assert property (@(posedge clk) disable iff (rst)
      (light_a == LT_GREEN && !sense_a) |=> (light_a == LT_YELLOW && light_b == LT_RED)); // R4

   AST_A_HANDOVER: assert property (@(posedge clk) disable iff (rst)
      (light_a == LT_YELLOW) |=> (light_a == LT_RED && light_b == LT_GREEN)); // R5

   AST_B_HOLD: assert property (@(posedge clk) disable iff (rst)
      (light_b == LT_GREEN && sense_b) |=> (light_b == LT_GREEN && light_a == LT_RED)); // R6

   AST_B_WARN: assert property (@(posedge clk) disable iff (rst)
      (light_b == LT_GREEN && !sense_b) |=> (light_b == LT_YELLOW && light_a == LT_RED)); // R7

   AST_B_HANDOVER: assert property (@(posedge clk) disable iff (rst)
      (light_b == LT_YELLOW) |=> (light_a == LT_GREEN && light_b == LT_RED)); // R8

   AST_ONE_ROAD_MOVES: assert property (@(posedge clk) disable iff (rst)
      (light_a == LT_RED || light_b == LT_RED)); // R9

endmodule

bind crossing_light_ctrl crossing_light_chk u_chk (
   .clk     (clk),
   .rst     (rst),
   .sense_a (sense_a),
   .sense_b (sense_b),
   .light_a (light_a),
   .light_b (light_b)
);

// File: tb/sim_crossing_light_ctrl.sv
`timescale 1ns/1ps
module sim_crossing_light_ctrl;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       sense_a = 1'b0;
   logic       sense_b = 1'b0;
   logic [1:0] light_a;
   logic [1:0] light_b;

   int checks = 0;
   int errors = 0;
   int ms = 0;          // model state: 0 A green, 1 A yellow, 2 B green, 3 B yellow
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   crossing_light_ctrl u0 (
      .clk     (clk),
      .rst     (rst),
      .sense_a (sense_a),
      .sense_b (sense_b),
      .light_a (light_a),
      .light_b (light_b)
   );

   function automatic logic [1:0] exp_a(int s);
      case (s)
         0: return 2'b00;
         1: return 2'b01;
         default: return 2'b10;
      endcase
   endfunction

   function automatic logic [1:0] exp_b(int s);
      case (s)
         2: return 2'b00;
         3: return 2'b01;
         default: return 2'b10;
      endcase
   endfunction

   function automatic int model_next(int s, bit a, bit b, bit r);
      if (r) return 0;
      case (s)
         0: return a ? 0 : 1;
         1: return 2;
         2: return b ? 2 : 3;
         default: return 0;
      endcase
   endfunction

   function automatic string tag_of(int s, bit a, bit b, bit r);
      if (r) return "R1";
      case (s)
         0: return a ? "R3" : "R4";
         1: return "R5";
         2: return b ? "R6" : "R7";
         default: return "R8";
      endcase
   endfunction

   task automatic check_pair(string tag);
      checks++;
      if (light_a !== exp_a(ms) || light_b !== exp_b(ms)) begin
         errors++;
         $display("FAIL %s: lights a=%b b=%b expected a=%b b=%b",
                  tag, light_a, light_b, exp_a(ms), exp_b(ms));
      end
   endtask

   task automatic check_invariants();
      checks++;
      if (light_a === 2'b11 || light_b === 2'b11) begin
         errors++;
         $display("FAIL R2: illegal code a=%b b=%b expected no 11", light_a, light_b);
      end
      checks++;
      if (light_a !== 2'b10 && light_b !== 2'b10) begin
         errors++;
         $display("FAIL R9: both roads active a=%b b=%b expected one red", light_a, light_b);
      end
   endtask

   // called at a negative edge: drive inputs, confirm lights hold (R10),
   // take the rising edge, advance the model, check at the next negative edge
   task automatic step(bit a, bit b, bit r);
      string t;
      sense_a = a;
      sense_b = b;
      rst     = r;
      #1;
      check_pair("R10");
      t = tag_of(ms, a, b, r);
      @(posedge clk);
      ms = model_next(ms, a, b, r);
      @(negedge clk);
      check_pair(t);
      check_invariants();
   endtask

   initial begin
      #(5.0 * 150000);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int seed = 1277;
      void'($urandom(seed));
      @(negedge clk);
      // R1: reset with sensors in both states
      step(1'b0, 1'b1, 1'b1);
      step(1'b1, 1'b0, 1'b1);

      // directed: hold A with B demanding (R3), then full cycle
      step(1'b1, 1'b1, 1'b0);
      step(1'b1, 1'b1, 1'b0);
      step(1'b0, 1'b1, 1'b0);   // R4
      step(1'b1, 1'b1, 1'b0);   // R5 ignores sensors
      step(1'b1, 1'b1, 1'b0);   // R6 ignores sense_a
      step(1'b1, 1'b0, 1'b0);   // R7
      step(1'b0, 1'b1, 1'b0);   // R8 ignores sensors
      step(1'b0, 1'b0, 1'b0);   // R4 from A green
      step(1'b0, 1'b0, 1'b0);   // R5
      step(1'b0, 1'b0, 1'b0);   // R7
      step(1'b1, 1'b1, 1'b0);   // R8

      // R1: reset from the middle of B green
      step(1'b0, 1'b0, 1'b0);
      step(1'b0, 1'b1, 1'b0);
      step(1'b0, 1'b1, 1'b1);

      // constrained random: long holds mixed with short bursts, rare reset
      for (int i = 0; i < 3000; i++) begin
         bit a = ($urandom % 4) != 0;
         bit b = ($urandom % 3) != 0;
         bit r = ($urandom % 200) == 0;
         step(a, b, r);
      end

      // R10: toggle sensors between edges without a clock edge
      for (int k = 0; k < 4; k++) begin
         sense_a = k[0];
         sense_b = k[1];
         #0.3;
         check_pair("R10");
      end

      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule